// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits in front of a scratchpad built from 32 banks, each one 4-byte word wide. It takes one request covering 32 lanes, each lane carrying a word address and an active bit. It then splits the request into passes that the banks can serve without conflict. A word lives in the bank given by the low five bits of its word address, so consecutive words fall in consecutive banks. In any pass each bank reads at most one word. Every pending lane that wants that exact word is served in the same pass, so one fetch fans out to any number of lanes. Only different words in the same bank force extra passes. The request therefore takes as many passes as the largest number of distinct words asked of any single bank.

Each pass presents a bank enable vector, a word address for every bank, and a lane mask that says which lanes the fetched data belongs to. The request side and the pass side are both valid/ready. The block takes a request only when it is idle (`in_ready` high), and a request is captured on the cycle where `in_valid` and `in_ready` are both high. A pass is retired on the cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the current pass holds steady. `stall` is high while passes remain. `done` pulses for one cycle after the last pass is retired.

Top module: `smem_conflict_sched`

## Requirements
- R1: The bank of a lane is its word address modulo 32 (address bits [4:0]). An enabled bank drives the full word address on its `out_bank_addr` slot; a bank with no enable drives zero there.
- R2: In a pass, every pending lane whose word equals the word picked for its bank is in `out_lane_mask`, so one fetch serves all lanes asking for that word.
- R3: Within a bank, a pass picks the word of the lowest-numbered pending lane mapped to that bank.
- R4: A request takes exactly as many passes as the largest count of distinct words in any one bank. A 32-word stride over 32 lanes takes 32 passes, and a 33-word stride takes 1.
- R5: Lanes with the active bit at 0 are never in any `out_lane_mask` and enable no bank.
- R6: `in_ready` is high only when no pass is pending. A request offered while passes remain is ignored and leaves the current passes unchanged.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_lane_mask`, `out_bank_en` and `out_bank_addr` hold their values.
- R8: `out_last` is high on the final pass. `done` is high for exactly one cycle, the cycle after the final pass is retired. A request with no active lane gets no pass, and `done` is high the cycle after it is accepted.
- R9: `stall` is high from the cycle after a request with active lanes is accepted until the final pass is retired.
- R10: After reset, `in_ready` is 1 and `out_valid`, `stall` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block idle, request can be taken |
| in_active | input | LANES | Active bit per lane, bit i is lane i |
| in_addr | input | LANES*AW | Word address per lane, lane i at bits [i*AW +: AW] |
| out_valid | output | 1 | A pass is presented |
| out_ready | input | 1 | Consumer takes the pass this cycle |
| out_bank_en | output | BANKS | Bank read enables, bit b is bank b |
| out_bank_addr | output | BANKS*AW | Word address per bank, bank b at bits [b*AW +: AW] |
| out_lane_mask | output | LANES | Lanes served by this pass |
| out_last | output | 1 | This pass is the final one of the request |
| stall | output | 1 | Passes remain for the current request |
| done | output | 1 | One-cycle pulse after the request completes |

## Verification
The bench sends lane addresses laid out as base plus lane times stride. A unit stride, a wrapped misaligned base and a 33-word stride must each finish in one pass. A zero stride checks that one word fans out to all lanes. Strides of 2, 16, 32 and 64 give conflicts of 2, 16, 32 and 8 ways, where the pass count and the per-pass masks separate true serialization from over- or under-splitting. Sparse and empty active masks check that idle lanes are left out. A hand-built case with two lanes sharing a word ahead of a lower-priority conflicting lane checks the pick order, pass hold under back-pressure and that a request offered while busy is refused.

// File: rtl/smem_sched_pkg.sv
package smem_sched_pkg;
  localparam int unsigned LANES_DEF = 32;
  localparam int unsigned BANKS_DEF = 32;
  localparam int unsigned AW_DEF    = 10;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/smem_bank_picker.sv
// Per-bank picker: the lowest pending lane mapped to this bank wins.
module smem_bank_picker #(
  parameter int unsigned LANES   = 32,
  parameter int unsigned AW      = 10,
  parameter int unsigned BW      = 5,
  parameter int unsigned BANK_ID = 0
) (
  input  logic [LANES-1:0]    pend_i,
  input  logic [LANES*AW-1:0] addr_i,
  output logic                en_o,
  output logic [AW-1:0]       word_o
);
  always_comb begin
    en_o   = 1'b0;
    word_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend_i[i] && (addr_i[i*AW +: BW] == BW'(BANK_ID))) begin
        en_o   = 1'b1;
        word_o = addr_i[i*AW +: AW];
      end
    end
  end
endmodule

// File: rtl/smem_lane_match.sv
// A pending lane is served when its bank fetches exactly its word.
module smem_lane_match #(
  parameter int unsigned LANES = 32,
  parameter int unsigned BANKS = 32,
  parameter int unsigned AW    = 10,
  parameter int unsigned BW    = 5
) (
  input  logic [LANES-1:0]    pend_i,
  input  logic [LANES*AW-1:0] addr_i,
  input  logic [BANKS-1:0]    bank_en_i,
  input  logic [BANKS*AW-1:0] bank_word_i,
  output logic [LANES-1:0]    served_o
);
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      served_o[i] = pend_i[i]
                 && bank_en_i[addr_i[i*AW +: BW]]
                 && (bank_word_i[int'(addr_i[i*AW +: BW])*AW +: AW] == addr_i[i*AW +: AW]);
    end
  end
endmodule

// File: rtl/smem_conflict_sched.sv
module smem_conflict_sched
  import smem_sched_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  parameter int unsigned BANKS = BANKS_DEF,
  parameter int unsigned AW    = AW_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES-1:0]    in_active,
  input  logic [LANES*AW-1:0] in_addr,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [BANKS-1:0]    out_bank_en,
  output logic [BANKS*AW-1:0] out_bank_addr,
  output logic [LANES-1:0]    out_lane_mask,
  output logic                out_last,
  output logic                stall,
  output logic                done
);
  localparam int unsigned BW = idx_bits(BANKS);

  logic [LANES-1:0]    pend_q;
  logic [LANES*AW-1:0] addr_q;
  logic                done_q;
  logic [LANES-1:0]    served;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    smem_bank_picker #(
      .LANES(LANES), .AW(AW), .BW(BW), .BANK_ID(b)
    ) u_pick (
      .pend_i (pend_q),
      .addr_i (addr_q),
      .en_o   (out_bank_en[b]),
      .word_o (out_bank_addr[b*AW +: AW])
    );
  end

  smem_lane_match #(
    .LANES(LANES), .BANKS(BANKS), .AW(AW), .BW(BW)
  ) u_match (
    .pend_i      (pend_q),
    .addr_i      (addr_q),
    .bank_en_i   (out_bank_en),
    .bank_word_i (out_bank_addr),
    .served_o    (served)
  );

  assign in_ready      = ~|pend_q;
  assign out_valid     = |pend_q;
  assign stall         = |pend_q;
  assign out_lane_mask = served;
  assign out_last      = out_valid && (served == pend_q);
  assign done          = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (in_valid && in_ready) begin
        pend_q <= in_active;
        addr_q <= in_addr;
        done_q <= ~|in_active;
      end else if (out_valid && out_ready) begin
        pend_q <= pend_q & ~served;
        done_q <= out_last;
      end
    end
  end
endmodule

// File: rtl/smem_conflict_sched_chk.sv
module smem_conflict_sched_chk #(
  parameter int unsigned LANES = 32,
  parameter int unsigned BANKS = 32,
  parameter int unsigned AW    = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [LANES-1:0]    in_active,
  input logic                out_valid,
  input logic                out_ready,
  input logic [BANKS-1:0]    out_bank_en,
  input logic [BANKS*AW-1:0] out_bank_addr,
  input logic [LANES-1:0]    out_lane_mask,
  input logic                out_last,
  input logic                stall,
  input logic                done
);
  // Lanes still owed data, rebuilt from port traffic only.
  logic [LANES-1:0] owed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) owed_q <= '0;
    else if (in_valid && in_ready) owed_q <= in_active;
    else if (out_valid && out_ready) owed_q <= owed_q & ~out_lane_mask;
  end

  assert_mask_owed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_lane_mask & ~owed_q) == '0) && (out_lane_mask != '0));

  assert_bank_used_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bank_en != '0) && ($countones(out_bank_en) <= $countones(out_lane_mask)));

  assert_stall_owed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall == (owed_q != '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_lane_mask)
      && $stable(out_bank_en) && $stable(out_bank_addr));

  assert_last_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> out_lane_mask == owed_q);

  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_last)
          || $past(in_valid && in_ready && (in_active == '0)));

  assert_busy_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_active != '0)) |=> stall && !in_ready);
endmodule

bind smem_conflict_sched smem_conflict_sched_chk #(
  .LANES(LANES), .BANKS(BANKS), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_active(in_active), .out_valid(out_valid), .out_ready(out_ready),
  .out_bank_en(out_bank_en), .out_bank_addr(out_bank_addr),
  .out_lane_mask(out_lane_mask), .out_last(out_last), .stall(stall), .done(done)
);

// File: tb/smem_conflict_sched_tb.sv
`timescale 1ns/1ps
module smem_conflict_sched_tb;
  localparam int LN = 32;
  localparam int BK = 32;
  localparam int AW = 10;
  localparam int WB = BK * AW;

  typedef struct packed {
    logic [9:0]  base;
    logic [9:0]  stride;
    logic [31:0] act;
    logic [7:0]  passes;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{10'd0,  10'd1,  32'hFFFF_FFFF, 8'd1},   // consecutive words
    '{10'd0,  10'd32, 32'hFFFF_FFFF, 8'd32},  // column over 32-word pitch
    '{10'd0,  10'd33, 32'hFFFF_FFFF, 8'd1},   // padded 33-word pitch
    '{10'd7,  10'd0,  32'hFFFF_FFFF, 8'd1},   // broadcast one word
    '{10'd0,  10'd2,  32'hFFFF_FFFF, 8'd2},   // 2-way
    '{10'd3,  10'd64, 32'h0000_00FF, 8'd8},   // 8 lanes in bank 3
    '{10'd9,  10'd1,  32'h0000_0000, 8'd0},   // nothing active
    '{10'd0,  10'd16, 32'hFFFF_FFFF, 8'd16},  // 16-way
    '{10'd1,  10'd1,  32'hAAAA_AAAA, 8'd1},   // sparse lanes
    '{10'd20, 10'd1,  32'hFFFF_FFFF, 8'd1}    // misaligned base, wraps banks
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [LN-1:0] in_active = '0;
  logic [LN*AW-1:0] in_addr = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [BK-1:0] out_bank_en;
  logic [WB-1:0] out_bank_addr;
  logic [LN-1:0] out_lane_mask;
  logic          out_last;
  logic          stall;
  logic          done;

  int nchk = 0;
  int nfail = 0;
  logic [AW-1:0] a [LN];

  always #2.5 clk = ~clk;

  smem_conflict_sched u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_active(in_active), .in_addr(in_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_bank_en(out_bank_en), .out_bank_addr(out_bank_addr),
    .out_lane_mask(out_lane_mask), .out_last(out_last), .stall(stall), .done(done)
  );

  task automatic chk(input string req, input string what,
                     input logic [WB-1:0] act, input logic [WB-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [LN*AW-1:0] pack_addr();
    logic [LN*AW-1:0] v = '0;
    for (int i = 0; i < LN; i++) v[i*AW +: AW] = a[i];
    return v;
  endfunction

  // Expected pass from the requirements: lowest pending lane picks the word of its bank.
  task automatic model(input logic [LN-1:0] pend, output logic [LN-1:0] m,
                       output logic [BK-1:0] en, output logic [WB-1:0] w);
    m = '0; en = '0; w = '0;
    for (int b = 0; b < BK; b++) begin
      int pick = -1;
      for (int i = LN - 1; i >= 0; i--)
        if (pend[i] && (int'(a[i]) % BK == b)) pick = i;
      if (pick >= 0) begin
        en[b] = 1'b1;
        w[b*AW +: AW] = a[pick];
        for (int j = 0; j < LN; j++)
          if (pend[j] && a[j] == a[pick]) m[j] = 1'b1;
      end
    end
  endtask

  task automatic run_req(input logic [LN-1:0] act, input int exp_passes);
    logic [LN-1:0] pend, m;
    logic [BK-1:0] en;
    logic [WB-1:0] w;
    int n = 0;
    @(negedge clk);
    in_active = act; in_addr = pack_addr(); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    pend = act;
    while (pend != '0 && n < 64) begin
      model(pend, m, en, w);
      chk("R9", "stall while pending", WB'(stall), WB'(1));
      chk("R6", "in_ready while pending", WB'(in_ready), WB'(0));
      chk("R2", "lane mask", WB'(out_lane_mask), WB'(m));
      chk("R5", "bank enables", WB'(out_bank_en), WB'(en));
      chk("R1", "bank addresses", out_bank_addr, w);
      chk("R8", "last flag", WB'(out_last), WB'(m == pend));
      @(negedge clk);
      pend = pend & ~m;
      n++;
    end
    chk("R4", "pass count", WB'(n), WB'(exp_passes));
    chk("R8", "done pulse", WB'(done), WB'(1));
    chk("R9", "stall after last", WB'(stall), WB'(0));
    chk("R6", "ready after last", WB'(in_ready), WB'(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R10", "reset in_ready", WB'(in_ready), WB'(1));
    chk("R10", "reset out_valid", WB'(out_valid), WB'(0));
    chk("R10", "reset stall", WB'(stall), WB'(0));
    chk("R10", "reset done", WB'(done), WB'(0));

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < LN; i++) a[i] = AW'(int'(VT[v].base) + int'(VT[v].stride) * i);
      run_req(VT[v].act, int'(VT[v].passes));
    end

    // R3 pick order, R7 hold, R6 refusal while busy.
    for (int i = 0; i < LN; i++) a[i] = '0;
    a[0] = 10'd64; a[1] = 10'd0; a[2] = 10'd64;
    @(negedge clk);
    in_active = 32'h7; in_addr = pack_addr(); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3", "first mask", WB'(out_lane_mask), WB'(32'h5));
    chk("R3", "first enables", WB'(out_bank_en), WB'(32'h1));
    chk("R3", "first word", out_bank_addr, WB'(64));
    chk("R8", "first not last", WB'(out_last), WB'(0));
    out_ready = 1'b0;
    in_valid = 1'b1; in_active = '1; in_addr = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7", "held valid", WB'(out_valid), WB'(1));
      chk("R7", "held mask", WB'(out_lane_mask), WB'(32'h5));
      chk("R7", "held word", out_bank_addr, WB'(64));
      chk("R6", "refuse while busy", WB'(in_ready), WB'(0));
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R3", "second mask", WB'(out_lane_mask), WB'(32'h2));
    chk("R6", "busy request ignored", out_bank_addr, WB'(0));
    chk("R8", "second is last", WB'(out_last), WB'(1));
    @(negedge clk);
    chk("R8", "done after last", WB'(done), WB'(1));
    chk("R9", "stall cleared", WB'(stall), WB'(0));
    @(negedge clk);
    chk("R8", "done one cycle", WB'(done), WB'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule